// File: doc/BRIEF.md
# Dual Timer/Counter Pair

This block provides two independent timer/counters, each made of a low byte and a high byte, for a small 8-bit controller. A shared prescaler divides the input clock into machine cycles. On each machine cycle, each timer either advances or holds, according to its mode, its count-source select, its gate and its run bit. In counter mode a timer counts falling edges on its external pin instead of machine cycles. When a timer overflows, it raises a flag that an interrupt controller can pick up. The interrupt controller, the serial port and the processor core are outside this block.

There are four modes. Mode 0 is a 13-bit counter. Mode 1 is a 16-bit counter. Mode 2 is an 8-bit counter that reloads itself from the high byte. Mode 3 depends on the timer. For Timer 0 it splits the timer into two 8-bit counters, and the upper one borrows the run bit and the overflow flag of Timer 1. For Timer 1 it stops the timer.

Every overflow of Timer 1 also produces a one-cycle strobe for a baud-rate generator. Software reaches the four count bytes and the two flags through a small register port.

Top module: `dual_timer_pair`

## Requirements
- R1: In mode 1 (mode field 2'b01) a timer counts through all 16 bits, with the high byte above the low byte. Stepping from 0xFFFF to 0x0000 sets that timer's overflow flag.
- R2: In mode 2 (mode field 2'b10) only the low byte counts. When the low byte steps past 0xFF, it is loaded from the high byte and the overflow flag is set. The high byte never changes through counting.
- R3: In mode 0 (mode field 2'b00) the count is a 13-bit value: the high byte forms bits 12..5 and low-byte bits 4..0 form bits 4..0. Low-byte bits 7..5 keep their value. Wrapping from 0x1FFF sets the overflow flag.
- R4: When Timer 1 is in mode 3 (2'b11), its count bytes hold. Taking it out of mode 3 lets it count again.
- R5: When Timer 0 is in mode 3, its low byte is an 8-bit counter. This counter uses Timer 0's select, gate, gate pin and run bit, and sets the Timer 0 flag when it wraps.
- R6: When Timer 0 is in mode 3, its high byte counts machine cycles while the Timer 1 run bit is 1, and sets the Timer 1 flag when it wraps.
- R7: While Timer 0 is in mode 3, Timer 1 counts in modes 0–2 whatever its run bit is, subject only to its gate. Its overflows produce the baud strobe but do not set the Timer 1 flag.
- R8: With select 0 a timer advances once per machine cycle, which is OSC_DIV clocks. It advances only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R9: With select 1 the external pin is sampled once per machine cycle. A sample of 0 that follows a sample of 1 counts once.
- R10: Each overflow flag is set by hardware. It is cleared by that timer's acknowledge input, or by a register write of 0 to its bit. If an overflow falls in the same cycle as a clear, the flag ends up set.
- R11: The register map is as follows. Address 0 is the Timer 0 low byte, 1 the Timer 0 high byte, 2 the Timer 1 low byte, 3 the Timer 1 high byte. Address 4 holds the flags: bit 0 for Timer 0, bit 1 for Timer 1. Any other address reads 0. Reset clears every byte and both flags.
- R12: Each Timer 1 overflow in modes 0–2 produces exactly one one-clock pulse on the baud strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| t0_mode | input | 2 | Timer 0 mode |
| t0_cnt_sel | input | 1 | Timer 0 source: 0 = machine cycles, 1 = pin |
| t0_gate | input | 1 | Timer 0 gate enable |
| t0_run | input | 1 | Timer 0 run bit |
| t0_gate_pin | input | 1 | Timer 0 external gate level |
| t0_cnt_pin | input | 1 | Timer 0 external count pin |
| t0_ack | input | 1 | Clears the Timer 0 flag |
| t1_mode | input | 2 | Timer 1 mode |
| t1_cnt_sel | input | 1 | Timer 1 source select |
| t1_gate | input | 1 | Timer 1 gate enable |
| t1_run | input | 1 | Timer 1 run bit |
| t1_gate_pin | input | 1 | Timer 1 external gate level |
| t1_cnt_pin | input | 1 | Timer 1 external count pin |
| t1_ack | input | 1 | Clears the Timer 1 flag |
| t0_flag | output | 1 | Timer 0 overflow flag |
| t1_flag | output | 1 | Timer 1 overflow flag |
| t1_baud_pulse | output | 1 | One-clock strobe per Timer 1 overflow |

## Verification
A hardware overflow and an acknowledge clear of the same flag can land in the same clock. To provoke this, the bench holds the Timer 0 acknowledge high throughout a run in mode 2 whose preload produces two wraps. Because set wins over clear, the flag must be high for exactly one clock after each wrap. The bench therefore counts the clocks in which the flag is high and expects two, and it expects the flag to be low once the run ends.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        TM_13BIT   = 2'b00,
        TM_16BIT   = 2'b01,
        TM_8RELOAD = 2'b10,
        TM_SPLIT   = 2'b11
    } tmode_e;

    localparam logic [ADDR_W-1:0] A_T0_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_T0_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_T1_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_T1_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_pair_t;
endpackage

// File: rtl/mc_tick.sv
module mc_tick #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == CW'(DIV - 1));

    generate
        if (DIV > 1) begin : g_gap
            // R8: a machine cycle spans several clocks
            a_r8_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pin_edge.sv
module pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic last;

    always_ff @(posedge clk) begin
        if (rst)       last <= 1'b0;
        else if (tick) last <= pin;
    end

    assign fall = tick && last && !pin;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tmode_e            mode,
    input  logic              split,
    input  logic              inc_lo,
    input  logic              inc_hi,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] wdata,
    output cnt_pair_t         cnt,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    cnt_pair_t nxt;

    always_comb begin
        nxt    = cnt;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        if (we_lo || we_hi) begin
            if (we_lo) nxt.lo = wdata;
            if (we_hi) nxt.hi = wdata;
        end else if (split) begin
            if (inc_lo) {ovf_lo, nxt.lo} = {1'b0, cnt.lo} + 9'd1;
            if (inc_hi) {ovf_hi, nxt.hi} = {1'b0, cnt.hi} + 9'd1;
        end else if (inc_lo) begin
            case (mode)
                TM_13BIT:
                    {ovf_lo, nxt.hi, nxt.lo[4:0]} = {1'b0, cnt.hi, cnt.lo[4:0]} + 14'd1;
                TM_16BIT:
                    {ovf_lo, nxt.hi, nxt.lo} = {1'b0, cnt.hi, cnt.lo} + 17'd1;
                TM_8RELOAD: begin
                    if (cnt.lo == '1) begin
                        nxt.lo = cnt.hi;
                        ovf_lo = 1'b1;
                    end else begin
                        nxt.lo = cnt.lo + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= nxt;
    end

    // R2: counting in reload mode never touches the high byte
    a_r2_reload_hi_kept: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_8RELOAD && !split && !we_hi) |=> $stable(cnt.hi));
    // R3: 13-bit mode leaves the low byte's upper three bits alone
    a_r3_upper_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_13BIT && !split && !we_lo) |=> $stable(cnt.lo[7:5]));
endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair
    import timer_pkg::*;
#(
    parameter int OSC_DIV = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [1:0]  t0_mode,
    input  logic        t0_cnt_sel,
    input  logic        t0_gate,
    input  logic        t0_run,
    input  logic        t0_gate_pin,
    input  logic        t0_cnt_pin,
    input  logic        t0_ack,
    input  logic [1:0]  t1_mode,
    input  logic        t1_cnt_sel,
    input  logic        t1_gate,
    input  logic        t1_run,
    input  logic        t1_gate_pin,
    input  logic        t1_cnt_pin,
    input  logic        t1_ack,
    output logic        t0_flag,
    output logic        t1_flag,
    output logic        t1_baud_pulse
);
    logic      tick;
    logic [1:0] cpin, fall, ev, set, ack, tf;
    tmode_e    m0, m1;
    logic      split0, en0, en1;
    cnt_pair_t c0, c1;
    logic      ovf0_lo, ovf0_hi, ovf1_lo, ovf1_hi;
    logic      we_flags;

    assign m0     = tmode_e'(t0_mode);
    assign m1     = tmode_e'(t1_mode);
    assign split0 = (m0 == TM_SPLIT);
    assign cpin   = {t1_cnt_pin, t0_cnt_pin};
    assign ack    = {t1_ack, t0_ack};

    mc_tick #(.DIV(OSC_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    generate
        for (genvar i = 0; i < 2; i++) begin : g_edge
            pin_edge u_edge (
                .clk(clk), .rst(rst), .tick(tick), .pin(cpin[i]), .fall(fall[i])
            );
        end
    endgenerate

    assign ev[0] = t0_cnt_sel ? fall[0] : tick;
    assign ev[1] = t1_cnt_sel ? fall[1] : tick;

    assign en0 = t0_run && (!t0_gate || t0_gate_pin);
    assign en1 = (m1 != TM_SPLIT) && (split0 || t1_run) && (!t1_gate || t1_gate_pin);

    tmr_core u_t0 (
        .clk(clk), .rst(rst), .mode(m0), .split(split0),
        .inc_lo(en0 && ev[0]), .inc_hi(split0 && t1_run && tick),
        .we_lo(bus_we && bus_addr == A_T0_LO), .we_hi(bus_we && bus_addr == A_T0_HI),
        .wdata(bus_wdata), .cnt(c0), .ovf_lo(ovf0_lo), .ovf_hi(ovf0_hi)
    );

    tmr_core u_t1 (
        .clk(clk), .rst(rst), .mode(m1), .split(1'b0),
        .inc_lo(en1 && ev[1]), .inc_hi(1'b0),
        .we_lo(bus_we && bus_addr == A_T1_LO), .we_hi(bus_we && bus_addr == A_T1_HI),
        .wdata(bus_wdata), .cnt(c1), .ovf_lo(ovf1_lo), .ovf_hi(ovf1_hi)
    );

    assign set[0]   = ovf0_lo;
    assign set[1]   = (split0 ? ovf0_hi : ovf1_lo) | ovf1_hi;
    assign we_flags = bus_we && bus_addr == A_FLAGS;

    generate
        for (genvar i = 0; i < 2; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)           tf[i] <= 1'b0;
                else if (set[i])   tf[i] <= 1'b1;
                else if (we_flags) tf[i] <= bus_wdata[i];
                else if (ack[i])   tf[i] <= 1'b0;
            end
            // R10: a hardware overflow beats any clear in the same cycle
            a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
                set[i] |=> tf[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) t1_baud_pulse <= 1'b0;
        else     t1_baud_pulse <= ovf1_lo;
    end

    assign t0_flag = tf[0];
    assign t1_flag = tf[1];

    always_comb begin
        case (bus_addr)
            A_T0_LO: bus_rdata = c0.lo;
            A_T0_HI: bus_rdata = c0.hi;
            A_T1_LO: bus_rdata = c1.lo;
            A_T1_HI: bus_rdata = c1.hi;
            A_FLAGS: bus_rdata = {6'd0, tf};
            default: bus_rdata = '0;
        endcase
    end

    // R4: Timer 1 in mode 3 holds its bytes unless software writes them
    a_r4_t1_frozen: assert property (@(posedge clk) disable iff (rst)
        (t1_mode == 2'b11 && !(bus_we && (bus_addr == A_T1_LO || bus_addr == A_T1_HI)))
        |=> ($stable(c1.lo) && $stable(c1.hi)));
    // R6: split high byte idles while the Timer 1 run bit is low
    a_r6_split_hi_idle: assert property (@(posedge clk) disable iff (rst)
        (t0_mode == 2'b11 && !t1_run && !(bus_we && bus_addr == A_T0_HI))
        |=> $stable(c0.hi));
    // R12: the baud strobe lasts one clock
    a_r12_baud_single: assert property (@(posedge clk) disable iff (rst)
        t1_baud_pulse |=> !t1_baud_pulse);
endmodule

// File: tb/test_dual_timer_pair.sv
`timescale 1ns/1ps
module test_dual_timer_pair;
    localparam int DIV = 6;

    logic clk = 0, rst = 1;
    logic bus_we = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [1:0] t0_mode = 0, t1_mode = 0;
    logic t0_cnt_sel = 0, t0_gate = 0, t0_run = 0, t0_gate_pin = 0, t0_cnt_pin = 0, t0_ack = 0;
    logic t1_cnt_sel = 0, t1_gate = 0, t1_run = 0, t1_gate_pin = 0, t1_cnt_pin = 0, t1_ack = 0;
    logic t0_flag, t1_flag, t1_baud_pulse;

    int checks = 0, errors = 0;
    int baud_cnt = 0, flag_hi_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_timer_pair #(.OSC_DIV(DIV)) i_dual_timer_pair (.*);

    always @(negedge clk) begin
        if (t1_baud_pulse) baud_cnt++;
        if (t0_flag) flag_hi_cnt++;
    end

    task automatic check(string req, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // runs for n machine cycles: exactly n ticks fall in 6n clocks
    task automatic run_ticks(int n, bit r0, bit r1);
        @(negedge clk);
        t0_run = r0; t1_run = r1;
        repeat (n * DIV) @(negedge clk);
        t0_run = 0; t1_run = 0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R11 reset/readback", d, 0);
        end
        check("R11 reset flag0", t0_flag, 0);
    endtask

    task automatic t_mode1;
        logic [7:0] d;
        t0_mode = 2'b01;
        wr(0, 8'hFD); wr(1, 8'hFF);
        run_ticks(5, 1, 0);
        rd(0, d); check("R1 lo", d, 8'h02);
        rd(1, d); check("R1 hi", d, 8'h00);
        check("R1 flag", t0_flag, 1);
        @(negedge clk) t0_ack = 1;
        @(negedge clk) t0_ack = 0;
        check("R10 ack clears", t0_flag, 0);
    endtask

    task automatic t_mode0;
        logic [7:0] d;
        t0_mode = 2'b00;
        wr(0, 8'hFE); wr(1, 8'hFF);
        run_ticks(3, 1, 0);
        rd(0, d); check("R3 lo keeps 7..5", d, 8'hE1);
        rd(1, d); check("R3 hi", d, 8'h00);
        check("R3 flag", t0_flag, 1);
        wr(4, 8'h00);
        check("R10 write clears", t0_flag, 0);
    endtask

    task automatic t_mode2;
        logic [7:0] d;
        int b0;
        t1_mode = 2'b10;
        wr(2, 8'hFE); wr(3, 8'hF0);
        b0 = baud_cnt;
        run_ticks(4, 0, 1);
        rd(2, d); check("R2 lo reload", d, 8'hF2);
        rd(3, d); check("R2 hi kept", d, 8'hF0);
        check("R2 flag1", t1_flag, 1);
        check("R12 baud pulses", baud_cnt - b0, 1);
        wr(4, 8'h00);
    endtask

    task automatic t_split;
        logic [7:0] d;
        t0_mode = 2'b11; t1_mode = 2'b11;
        wr(0, 8'hFE); wr(1, 8'hFD); wr(2, 8'h12); wr(3, 8'h34);
        run_ticks(3, 1, 1);
        rd(0, d); check("R5 split lo", d, 8'h01);
        check("R5 flag0", t0_flag, 1);
        rd(1, d); check("R6 split hi", d, 8'h00);
        check("R6 flag1", t1_flag, 1);
        rd(2, d); check("R4 t1 lo frozen", d, 8'h12);
        rd(3, d); check("R4 t1 hi frozen", d, 8'h34);
        wr(4, 8'h00);
    endtask

    task automatic t_split_t1_runs;
        logic [7:0] d;
        int b0;
        t0_mode = 2'b11; t1_mode = 2'b10;
        wr(1, 8'h55); wr(2, 8'hFE); wr(3, 8'h00);
        b0 = baud_cnt;
        run_ticks(3, 0, 0);
        rd(2, d); check("R7 t1 counts without run", d, 8'h01);
        check("R7 baud", baud_cnt - b0, 1);
        check("R7 flag1 untouched", t1_flag, 0);
        rd(1, d); check("R6 hi idle without t1 run", d, 8'h55);
        t0_mode = 2'b00; t1_mode = 2'b00;
    endtask

    task automatic t_gate;
        logic [7:0] d;
        t0_mode = 2'b01; t0_gate = 1; t0_gate_pin = 0;
        wr(0, 8'h00); wr(1, 8'h00);
        run_ticks(4, 1, 0);
        rd(0, d); check("R8 gate low blocks", d, 8'h00);
        t0_gate_pin = 1;
        run_ticks(3, 1, 0);
        rd(0, d); check("R8 gate high counts", d, 8'h03);
        t0_gate = 0; t0_gate_pin = 0;
    endtask

    task automatic t_counter;
        logic [7:0] d;
        t0_mode = 2'b01; t0_cnt_sel = 1;
        wr(0, 8'h00);
        @(negedge clk);
        t0_cnt_pin = 1; t0_run = 1;
        for (int k = 0; k < 3; k++) begin
            t0_cnt_pin = 1; repeat (4 * DIV) @(negedge clk);
            t0_cnt_pin = 0; repeat (4 * DIV) @(negedge clk);
        end
        t0_run = 0;
        rd(0, d); check("R9 falling edges", d, 8'h03);
        t0_cnt_sel = 0;
    endtask

    task automatic t_collision;
        logic [7:0] d;
        t0_mode = 2'b10;
        wr(0, 8'hFE); wr(1, 8'hFE);
        @(negedge clk);
        t0_ack = 1; flag_hi_cnt = 0;
        run_ticks(4, 1, 0);
        repeat (2) @(negedge clk);
        check("R10 set beats ack", flag_hi_cnt, 2);
        t0_ack = 0;
        check("R10 flag low after", t0_flag, 0);
        rd(0, d); check("R2 reload lo", d, 8'hFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_mode1();
        t_mode0();
        t_mode2();
        t_split();
        t_split_t1_runs();
        t_gate();
        t_counter();
        t_collision();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule